// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This unit sits beside the decode stage of a 32-bit processor that has one delay slot after each branch. Every cycle it receives an instruction word, the address of that instruction and the two source register values read for it. It decides whether the instruction transfers control and computes the candidate target address. It also reports whether the delay-slot instruction that follows must be discarded, and whether the return address has to be written into register 31.

All results are registered, so they appear one clock after the inputs. The unit covers two-register equality branches, sign and zero tests of one register, the condition group selected by the second register field, the "likely" forms that discard their delay slot when they fall through, and absolute jumps with and without a link. For a code that this group does not define, the unit raises an illegal-instruction flag. Register file access, fetch redirection and pipeline control are left to the surrounding logic.

Top module: `ctl_xfer_resolve`

## Requirements
- R1: While `rst` is high, all outputs are zero at the next clock edge.
- R2: Every output reflects the inputs of the previous cycle. `link_value` always equals that cycle's `pc` + 8, whatever the opcode.
- R3: Primary opcode (instr[31:26]) 4 is taken when `opnd_a` == `opnd_b`, and opcode 5 when they differ. For every non-jump opcode, `target` = `pc` + 4 + (sign-extended instr[15:0] << 2).
- R4: Opcode 6 is taken when `opnd_a` is negative or zero. Opcode 7 is taken when `opnd_a` has bit 31 clear and is nonzero.
- R5: Opcodes 2 and 3 are always taken, with `target` = {pc[31:28], instr[25:0], 2'b00}. Opcode 3 also raises `link_we`.
- R6: Opcodes 20, 21, 22 and 23 use the conditions of 4, 5, 6 and 7. They raise `annul` exactly when not taken. Non-likely forms never raise `annul`.
- R7: With opcode 1, the condition comes from instr[20:16]. Code bit 0 clear tests `opnd_a` < 0, and bit 0 set tests `opnd_a` >= 0. Codes 2, 3, 0x12 and 0x13 are likely forms. Codes 0x10 to 0x13 raise `link_we` whether or not the branch is taken.
- R8: With opcode 1, any code in instr[20:16] other than 0 to 3 and 0x10 to 0x13 raises `illegal` and leaves `taken`, `annul` and `link_we` low.
- R9: All other opcodes leave `taken`, `annul`, `link_we` and `illegal` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 32 | Instruction word |
| pc | input | 32 | Address of the instruction |
| opnd_a | input | 32 | Value of the first source register |
| opnd_b | input | 32 | Value of the second source register |
| taken | output | 1 | Control transfer taken |
| annul | output | 1 | Discard the delay-slot instruction |
| link_we | output | 1 | Write `link_value` into register 31 |
| illegal | output | 1 | Undefined condition code |
| target | output | 32 | Transfer target address |
| link_value | output | 32 | Return address, pc + 8 |

## Verification
The assertions check several rules on every cycle. A raised `annul` never comes with `taken`, and a raised `illegal` suppresses the transfer and the link. Jumps are always taken one cycle later, and a likely branch yields exactly one of taken or annul. The linking condition codes always request the write, and `link_value` tracks `pc` + 8. The comparison results themselves can only be shown by the bench scenarios, which compare every output against a reference model each cycle. These include the equality and sign boundaries (zero, 0x80000000, 0x7FFFFFFF), negative offsets, jump region bits and illegal codes.

// File: rtl/ctl_xfer_resolve.sv
module ctl_xfer_resolve (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] instr,
  input  logic [31:0] pc,
  input  logic [31:0] opnd_a,
  input  logic [31:0] opnd_b,
  output logic        taken,
  output logic        annul,
  output logic        link_we,
  output logic        illegal,
  output logic [31:0] target,
  output logic [31:0] link_value
);
  localparam logic [5:0] OP_COND = 6'd1;
  localparam logic [5:0] OP_J    = 6'd2;
  localparam logic [5:0] OP_JL   = 6'd3;
  localparam logic [5:0] OP_EQ   = 6'd4;
  localparam logic [5:0] OP_NE   = 6'd5;
  localparam logic [5:0] OP_LE   = 6'd6;
  localparam logic [5:0] OP_GT   = 6'd7;
  localparam logic [5:0] OP_EQL  = 6'd20;
  localparam logic [5:0] OP_NEL  = 6'd21;
  localparam logic [5:0] OP_LEL  = 6'd22;
  localparam logic [5:0] OP_GTL  = 6'd23;

  logic [5:0]  op;
  logic [4:0]  code;
  logic [31:0] br_tgt, jmp_tgt;
  logic        eq, a_neg, a_zero;

  assign op      = instr[31:26];
  assign code    = instr[20:16];
  assign br_tgt  = pc + 32'd4 + {{14{instr[15]}}, instr[15:0], 2'b00};
  assign jmp_tgt = {pc[31:28], instr[25:0], 2'b00};
  assign eq      = (opnd_a == opnd_b);
  assign a_neg   = opnd_a[31];
  assign a_zero  = (opnd_a == 32'd0);

  logic        n_tk, n_an, n_lk, n_il, hit, cnd, lik;
  logic [31:0] n_tg;

  always_comb begin
    n_tk = 1'b0;
    n_an = 1'b0;
    n_lk = 1'b0;
    n_il = 1'b0;
    n_tg = br_tgt;
    hit  = 1'b0;
    cnd  = 1'b0;
    lik  = 1'b0;
    case (op)
      OP_J:  begin n_tk = 1'b1; n_tg = jmp_tgt; end
      OP_JL: begin n_tk = 1'b1; n_tg = jmp_tgt; n_lk = 1'b1; end
      OP_EQ, OP_EQL: begin hit = 1'b1; cnd = eq; lik = op[4]; end
      OP_NE, OP_NEL: begin hit = 1'b1; cnd = !eq; lik = op[4]; end
      OP_LE, OP_LEL: begin hit = 1'b1; cnd = a_neg | a_zero; lik = op[4]; end
      OP_GT, OP_GTL: begin hit = 1'b1; cnd = !a_neg & !a_zero; lik = op[4]; end
      OP_COND: begin
        case (code)
          5'h00, 5'h01, 5'h02, 5'h03, 5'h10, 5'h11, 5'h12, 5'h13: begin
            hit  = 1'b1;
            cnd  = code[0] ? !a_neg : a_neg;
            lik  = code[1];
            n_lk = code[4];
          end
          default: n_il = 1'b1;
        endcase
      end
      default: ;
    endcase
    if (hit) begin
      n_tk = cnd;
      n_an = lik & !cnd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      taken      <= 1'b0;
      annul      <= 1'b0;
      link_we    <= 1'b0;
      illegal    <= 1'b0;
      target     <= 32'd0;
      link_value <= 32'd0;
    end else begin
      taken      <= n_tk;
      annul      <= n_an;
      link_we    <= n_lk;
      illegal    <= n_il;
      target     <= n_tg;
      link_value <= pc + 32'd8;
    end
  end
endmodule

// File: rtl/ctl_xfer_resolve_chk.sv
module ctl_xfer_resolve_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] instr,
  input logic [31:0] pc,
  input logic        taken,
  input logic        annul,
  input logic        link_we,
  input logic        illegal,
  input logic [31:0] link_value
);
  AST_ANNUL_EXCL: assert property (@(posedge clk) disable iff (rst)
    annul |-> !taken); // R6
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!taken && !annul && !link_we)); // R8
  AST_JUMP_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (instr[31:27] == 5'b00001) |=> (taken && !annul)); // R5
  AST_LIKELY_ONE: assert property (@(posedge clk) disable iff (rst)
    (instr[31:28] == 4'b0101) |=> (taken != annul)); // R6
  AST_COND_LINK: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == 6'd1 && instr[20:18] == 3'b100) |=> link_we); // R7
  AST_LINK_VALUE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (link_value == $past(pc) + 32'd8)); // R2
endmodule

bind ctl_xfer_resolve ctl_xfer_resolve_chk u_chk (.*);

// File: tb/test_ctl_xfer_resolve.sv
module test_ctl_xfer_resolve;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = 32'd0, pc = 32'd0, opnd_a = 32'd0, opnd_b = 32'd0;
  logic        taken, annul, link_we, illegal;
  logic [31:0] target, link_value;

  int checks = 0;
  int errors = 0;

  logic        e_tk, e_an, e_lk, e_il;
  logic [31:0] e_tg, e_lv;
  string       e_tag;

  ctl_xfer_resolve i_ctl_xfer_resolve (.*);

  always #4 clk = ~clk;

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic model();
    int op, rc;
    bit c, br, lk;
    op = int'(instr[31:26]);
    rc = int'(instr[20:16]);
    e_tk = 0; e_an = 0; e_lk = 0; e_il = 0; br = 0; c = 0; lk = 0;
    e_lv = pc + 8;
    e_tg = pc + 4 + 32'($signed(instr[15:0]) * 4);
    e_tag = "R9";
    if (op == 2 || op == 3) begin
      e_tk = 1; e_lk = (op == 3); e_tag = "R5";
      e_tg = (pc & 32'hF000_0000) | (32'(instr[25:0]) << 2);
    end else if (op == 4 || op == 20) begin br = 1; c = (opnd_a == opnd_b); e_tag = "R3"; end
    else if (op == 5 || op == 21) begin br = 1; c = (opnd_a != opnd_b); e_tag = "R3"; end
    else if (op == 6 || op == 22) begin br = 1; c = ($signed(opnd_a) <= 0); e_tag = "R4"; end
    else if (op == 7 || op == 23) begin br = 1; c = ($signed(opnd_a) > 0); e_tag = "R4"; end
    else if (op == 1) begin
      if ((rc >= 0 && rc <= 3) || (rc >= 16 && rc <= 19)) begin
        e_tag = "R7";
        c = (rc % 2 == 1) ? ($signed(opnd_a) >= 0) : ($signed(opnd_a) < 0);
        e_tk = c;
        e_an = (rc == 2 || rc == 3 || rc == 18 || rc == 19) && !c;
        e_lk = (rc >= 16);
      end else begin
        e_il = 1; e_tag = "R8";
      end
    end
    if (br) begin
      e_tk = c;
      if (op >= 20) begin e_an = !c; e_tag = "R6"; end
    end
  endtask

  task automatic compare();
    checks++;
    if ({taken, annul, link_we, illegal} !== {e_tk, e_an, e_lk, e_il} ||
        target !== e_tg || link_value !== e_lv) begin
      errors++;
      $display("FAIL %s/R2 instr=%h: got tk%b an%b lk%b il%b tg=%h lv=%h exp tk%b an%b lk%b il%b tg=%h lv=%h",
               e_tag, instr, taken, annul, link_we, illegal, target, link_value,
               e_tk, e_an, e_lk, e_il, e_tg, e_lv);
    end
  endtask

  task automatic step(input logic [31:0] i, input logic [31:0] p,
                      input logic [31:0] a, input logic [31:0] b);
    instr = i; pc = p; opnd_a = a; opnd_b = b;
    model();
    @(negedge clk);
    compare();
  endtask

  function automatic logic [31:0] mk(input int op, input int rt, input logic [15:0] off);
    return {6'(op), 5'd3, 5'(rt), off};
  endfunction

  initial begin
    instr = mk(2, 0, 16'h1234); pc = 32'h1000;
    repeat (2) @(negedge clk);
    checks++;
    if ({taken, annul, link_we, illegal} !== 4'b0000 || target !== 0 || link_value !== 0) begin
      errors++;
      $display("FAIL R1 reset: got %b %h %h exp 0000 0 0",
               {taken, annul, link_we, illegal}, target, link_value);
    end
    rst = 1'b0;
    step(mk(4, 5, 16'h0010), 32'h0000_4000, 32'd7, 32'd7);         // R3 eq taken
    step(mk(4, 5, 16'hFFFC), 32'h0000_4000, 32'd7, 32'd8);         // R3 negative offset
    step(mk(5, 5, 16'h0001), 32'h0000_4100, 32'd1, 32'd2);         // R3 ne
    step(mk(6, 0, 16'h0002), 32'h0000_4200, 32'd0, 32'd0);         // R4 zero
    step(mk(6, 0, 16'h0002), 32'h0000_4200, 32'h8000_0000, 32'd0); // R4 min
    step(mk(6, 0, 16'h0002), 32'h0000_4200, 32'd1, 32'd0);         // R4 positive
    step(mk(7, 0, 16'h0002), 32'h0000_4200, 32'h7FFF_FFFF, 32'd0); // R4 max
    step(mk(7, 0, 16'h0002), 32'h0000_4200, 32'd0, 32'd0);         // R4 zero not gt
    step({6'd2, 26'h3FF_FFFF}, 32'hA000_0010, 32'd0, 32'd0);       // R5 j
    step({6'd3, 26'h000_0040}, 32'h5FFF_FFFC, 32'd0, 32'd0);       // R5 jal
    step(mk(20, 5, 16'h0008), 32'h100, 32'd3, 32'd4);              // R6 beql miss
    step(mk(21, 5, 16'h0008), 32'h100, 32'd3, 32'd4);              // R6 bnel hit
    step(mk(22, 0, 16'h0008), 32'h100, 32'd5, 32'd0);              // R6 blezl miss
    step(mk(23, 0, 16'h0008), 32'h100, 32'd5, 32'd0);              // R6 bgtzl hit
    step(mk(1, 5'h00, 16'h0004), 32'h200, 32'hFFFF_FFFF, 32'd0);   // R7 ltz
    step(mk(1, 5'h01, 16'h0004), 32'h200, 32'd0, 32'd0);           // R7 gez zero
    step(mk(1, 5'h02, 16'h0004), 32'h200, 32'd0, 32'd0);           // R7 ltzl miss
    step(mk(1, 5'h10, 16'h0004), 32'h200, 32'd9, 32'd0);           // R7 link not taken
    step(mk(1, 5'h13, 16'h0004), 32'h200, 32'hF000_0000, 32'd0);   // R7 gezall miss
    step(mk(1, 5'h04, 16'h0004), 32'h200, 32'd0, 32'd0);           // R8
    step(mk(1, 5'h1F, 16'h0004), 32'h200, 32'hFFFF_FFFF, 32'd0);   // R8
    step(mk(8, 5, 16'h0004), 32'h300, 32'd0, 32'd0);               // R9
    step(mk(24, 5, 16'h0004), 32'h300, 32'd1, 32'd1);              // R9
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] a;
      int pick;
      pick = int'($urandom_range(0, 15));
      a = ($urandom_range(0, 3) == 0) ? 32'(pick) - 32'd2 : $urandom;
      if (pick < 8) begin
        instr = $urandom;
        instr[31:26] = 6'(pick < 4 ? pick + 1 : pick + 16);
      end else if (pick < 12) begin
        instr = $urandom;
        instr[31:26] = 6'd1;
        instr[20:16] = 5'($urandom_range(0, 3)) | (pick < 10 ? 5'h10 : 5'h00);
      end else begin
        instr = $urandom;
      end
      step(instr, $urandom, a, (pick % 2 == 0) ? a : $urandom);
    end
    rst = 1'b1;
    @(negedge clk);
    checks++;
    if ({taken, annul, link_we, illegal} !== 4'b0000) begin
      errors++;
      $display("FAIL R1 mid-run reset: got %b exp 0000", {taken, annul, link_we, illegal});
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule